// File: doc/BRIEF.md
# Intermittent-Fault Sequential Machine Emulator

This block is a small programmable finite-state machine that stands in for a circuit under test carrying one stationary intermittent fault. It has two states, a 1-bit input and a 1-bit output, and each output belongs to a transition: it depends on the present state and the present input. Two little transition tables are held inside. One describes the healthy machine. The other describes the machine while the fault is active. Each accepted input vector takes its next state and its output from exactly one of these tables.

For each vector an internal pseudo-random generator decides whether the fault is active. The choice has a fixed probability that is set by an 8-bit threshold, and it does not depend on the input value. A faulty transition may leave the machine in a wrong state without showing a wrong output at once. Because that wrong state is kept, an error can appear on a later vector, after the fault has gone quiet again. Reset is immune to the fault and always brings the machine back to its first state. A pulse output marks every vector that used the faulty table, so a test environment can compare the observed activity rate with the threshold it programmed.

Top module: `ifm_emulator`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `state_out` = 0 (the reset state), `z_out` = 0, `z_valid` = 0 and `fault_active` = 0.
- R2: A table entry is written only at an edge where both `rst` and `load_en` are high. `load_sel` picks the table (0 = healthy, 1 = faulty), `load_addr` picks the entry and `load_data` supplies it. When `rst` is low, `load_en` has no effect.
- R3: The entry index is {present state, input}, with the state in bit 1. The entry layout is {next state, output}, with the next state in bit 1.
- R4: When an accepted vector finds the fault inactive, both the next state and `z_out` come from the healthy table. They appear one cycle after the accepting edge, together with a one-cycle `z_valid` pulse.
- R5: When an accepted vector finds the fault active, both the next state and `z_out` come from the faulty table, and `fault_active` pulses alongside `z_valid`.
- R6: The fault is active for a vector when the top 8 bits of a 16-bit LFSR are numerically below `threshold`. The LFSR is a right-shifting Galois type with taps 0xB400, is seeded with 0xACE1 at reset, and steps once per accepted vector. A threshold of 0 therefore never activates the fault, and a threshold of 64 activates it on about a quarter of the vectors.
- R7: In a cycle without `vec_valid`, the state is held and neither `z_valid` nor `fault_active` pulses.
- R8: A state reached through a faulty transition is kept. The following healthy transitions start from that state, so a wrong output can appear after the fault is no longer active.
- R9: Reset wins over a vector presented in the same cycle. The vector is dropped and the machine returns to state 0 from any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the fault never touches it |
| load_en | input | 1 | Table write strobe; honoured only during reset |
| load_sel | input | 1 | Table select: 0 healthy, 1 faulty |
| load_addr | input | 2 | Entry index {state, input} |
| load_data | input | 2 | Entry value {next state, output} |
| threshold | input | 8 | Activity probability in 1/256 steps |
| vec_valid | input | 1 | An input vector is applied this cycle |
| vec_in | input | 1 | Input symbol |
| state_out | output | 1 | Present state |
| z_out | output | 1 | Output of the last accepted transition |
| z_valid | output | 1 | One-cycle pulse after each accepted vector |
| fault_active | output | 1 | One-cycle pulse when that vector used the faulty table |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a table write and a vector. The bench raises `load_en`, with new data for the very entry being read, in the same cycle as an accepted vector after reset has been released. It then checks that both that transition and a repeat of it still follow the old entry. The second pair is reset and a vector. The bench presents a vector on the edge where reset is asserted while the machine sits in state 1. It then expects state 0 with no `z_valid` pulse, so the reset must win and the vector must be discarded.

// File: rtl/ifm_pkg.sv
package ifm_pkg;

    localparam int STATE_W = 1;
    localparam int IN_W    = 1;
    localparam int OUT_W   = 1;
    localparam int LFSR_W  = 16;
    localparam int THR_W   = 8;
    localparam int NUM_TBL = 2;

    localparam int ADDR_W  = STATE_W + IN_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int ENTRY_W = STATE_W + OUT_W;

    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef struct packed {
        logic [STATE_W-1:0] nxt;
        logic [OUT_W-1:0]   out;
    } entry_t;

    typedef enum logic {
        TBL_HEALTHY = 1'b0,
        TBL_FAULTY  = 1'b1
    } tbl_sel_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
    endfunction

endpackage

// File: rtl/ifm_table.sv
module ifm_table
    import ifm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  entry_t            wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output entry_t            rd_data
);
    entry_t [DEPTH-1:0] mem;

    // Writes are honoured only while the machine is held in reset.
    always_ff @(posedge clk) begin
        if (rst && wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R2: outside reset the contents never change
    p_no_write_running_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mem));

endmodule

// File: rtl/ifm_activity.sv
module ifm_activity
    import ifm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic [THR_W-1:0] threshold,
    output logic             active
);
    logic [LFSR_W-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= LFSR_SEED;
        end else if (advance) begin
            lfsr_q <= lfsr_step(lfsr_q);
        end
    end

    assign active = (lfsr_q[LFSR_W-1 -: THR_W] < threshold);

    // R6: generator never locks up in the all-zero state
    p_lfsr_alive_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lfsr_q != '0));

    // R6: one step per accepted vector only
    p_lfsr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(lfsr_q));

endmodule

// File: rtl/ifm_emulator.sv
module ifm_emulator
    import ifm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_en,
    input  logic               load_sel,
    input  logic [ADDR_W-1:0]  load_addr,
    input  logic [ENTRY_W-1:0] load_data,
    input  logic [THR_W-1:0]   threshold,
    input  logic               vec_valid,
    input  logic [IN_W-1:0]    vec_in,
    output logic [STATE_W-1:0] state_out,
    output logic [OUT_W-1:0]   z_out,
    output logic               z_valid,
    output logic               fault_active
);
    logic [STATE_W-1:0] state_q;
    logic [ADDR_W-1:0]  rd_addr;
    entry_t             rd_entry [NUM_TBL];
    entry_t             chosen;
    logic               act;
    logic               accept;

    assign accept  = vec_valid && !rst;
    assign rd_addr = {state_q, vec_in};

    for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
        ifm_table u_tbl (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (load_en && (load_sel == g[0])),
            .wr_addr (load_addr),
            .wr_data (entry_t'(load_data)),
            .rd_addr (rd_addr),
            .rd_data (rd_entry[g])
        );
    end

    ifm_activity u_act (
        .clk       (clk),
        .rst       (rst),
        .advance   (accept),
        .threshold (threshold),
        .active    (act)
    );

    // One activity draw per vector selects the whole transition.
    always_comb begin
        chosen = act ? rd_entry[TBL_FAULTY] : rd_entry[TBL_HEALTHY];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= '0;
            z_out        <= '0;
            z_valid      <= 1'b0;
            fault_active <= 1'b0;
        end else begin
            z_valid      <= vec_valid;
            fault_active <= vec_valid && act;
            if (vec_valid) begin
                state_q <= chosen.nxt;
                z_out   <= chosen.out;
            end
        end
    end

    assign state_out = state_q;

    // R1 / R9: reset lands in state 0 with no pulses
    p_reset_home_r1: assert property (@(posedge clk)
        rst |=> (state_out == '0) && !z_valid && !fault_active);

    // R7: idle cycles produce no pulse and keep the state
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |=> !z_valid && !fault_active && $stable(state_out));

    // R5: activity is reported only for a reported vector
    p_active_with_valid_r5: assert property (@(posedge clk) disable iff (rst)
        fault_active |-> z_valid);

    // R6: zero threshold never activates the fault
    p_zero_thr_r6: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && threshold == '0) |=> !fault_active);

endmodule

// File: tb/ifm_emulator_test.sv
module ifm_emulator_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       load_en, load_sel;
    logic [1:0] load_addr, load_data;
    logic [7:0] threshold;
    logic       vec_valid, vec_in;
    logic       state_out, z_out, z_valid, fault_active;

    int checks   = 0;
    int failures = 0;

    // entries {next, out}, index {state, input}
    logic [1:0] healthy_t [4];
    logic [1:0] faulty_t  [4];
    logic       mstate;

    // stimulus rows: {threshold[7:0], input}
    localparam logic [8:0] STIM [20] = '{
        {8'd0,   1'b1}, {8'd0,   1'b0}, {8'd0,   1'b1}, {8'd0,   1'b1},
        {8'd255, 1'b0}, {8'd255, 1'b1}, {8'd255, 1'b0}, {8'd128, 1'b1},
        {8'd128, 1'b1}, {8'd128, 1'b0}, {8'd128, 1'b0}, {8'd64,  1'b1},
        {8'd64,  1'b0}, {8'd200, 1'b1}, {8'd200, 1'b1}, {8'd0,   1'b0},
        {8'd0,   1'b1}, {8'd255, 1'b1}, {8'd32,  1'b0}, {8'd0,   1'b1}
    };

    ifm_emulator uut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_sel(load_sel),
        .load_addr(load_addr), .load_data(load_data), .threshold(threshold),
        .vec_valid(vec_valid), .vec_in(vec_in), .state_out(state_out),
        .z_out(z_out), .z_valid(z_valid), .fault_active(fault_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input logic sel, input logic [1:0] a, input logic [1:0] d);
        @(negedge clk);
        load_en = 1'b1; load_sel = sel; load_addr = a; load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // apply one vector; outputs are sampled one negedge after the accepting edge
    task automatic apply(input logic v, input logic [7:0] thr, input string req);
        logic [1:0] e;
        @(negedge clk);
        vec_valid = 1'b1; vec_in = v; threshold = thr;
        @(negedge clk);
        vec_valid = 1'b0;
        e = fault_active ? faulty_t[{mstate, v}] : healthy_t[{mstate, v}];
        chk(z_valid == 1'b1, req, z_valid, 1);
        chk(z_out == e[0], req, z_out, e[0]);
        chk(state_out == e[1], req, state_out, e[1]);
        mstate = e[1];
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cnt;
        logic [1:0] e_ok;
        healthy_t = '{2'b00, 2'b10, 2'b10, 2'b01};
        faulty_t  = '{2'b10, 2'b10, 2'b10, 2'b00};
        rst = 1'b1; load_en = 1'b0; load_sel = 1'b0; load_addr = '0; load_data = '0;
        threshold = '0; vec_valid = 1'b0; vec_in = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            load(1'b0, 2'(i), healthy_t[i]);
            load(1'b1, 2'(i), faulty_t[i]);
        end
        // R1: reset state
        chk(state_out == 1'b0, "R1 state", state_out, 0);
        chk(z_valid == 1'b0, "R1 z_valid", z_valid, 0);
        chk(fault_active == 1'b0, "R1 fault_active", fault_active, 0);
        @(negedge clk); rst = 1'b0;
        mstate = 1'b0;

        // R3 / R4: healthy transitions with zero threshold
        apply(1'b1, 8'd0, "R3 q0,i1");
        chk(fault_active == 1'b0, "R6 thr0", fault_active, 0);
        apply(1'b1, 8'd0, "R3 q1,i1");

        // table walk: R4 / R5 / R8 through the model
        for (int k = 0; k < 20; k++) begin
            apply(STIM[k][0], STIM[k][8:1], "R4/R5 table walk");
            if (STIM[k][8:1] == 8'd0) chk(fault_active == 1'b0, "R6 thr0 walk", fault_active, 0);
        end

        // R7: idle cycles keep everything quiet
        repeat (3) begin
            @(negedge clk);
            chk(z_valid == 1'b0 && fault_active == 1'b0, "R7 idle", z_valid, 0);
            chk(state_out == mstate, "R7 hold", state_out, mstate);
        end

        // R9: reset with a vector in the same cycle, from state 1
        if (mstate == 1'b0) apply(1'b1, 8'd0, "R9 prep");
        chk(state_out == 1'b1, "R9 prep state", state_out, 1);
        @(negedge clk); rst = 1'b1; vec_valid = 1'b1; vec_in = 1'b1;
        @(negedge clk); rst = 1'b0; vec_valid = 1'b0;
        chk(state_out == 1'b0, "R9 state", state_out, 0);
        chk(z_valid == 1'b0, "R9 z_valid", z_valid, 0);
        mstate = 1'b0;

        // R2: load attempt outside reset, same cycle as a vector
        e_ok = healthy_t[0];
        @(negedge clk);
        load_en = 1'b1; load_sel = 1'b0; load_addr = 2'b00; load_data = 2'b11;
        vec_valid = 1'b1; vec_in = 1'b0; threshold = 8'd0;
        @(negedge clk);
        load_en = 1'b0; vec_valid = 1'b0;
        chk(state_out == e_ok[1] && z_out == e_ok[0], "R2 same cycle", {state_out, z_out}, e_ok);
        apply(1'b0, 8'd0, "R2 entry unchanged");

        // R8: faulty silent move q0 -> q1, then healthy step exposes it
        cnt = 0;
        do begin
            apply(1'b0, 8'd255, "R8 provoke");
            cnt++;
        end while (!fault_active && cnt < 10);
        chk(fault_active == 1'b1 && z_out == 1'b0, "R8 silent fault", fault_active, 1);
        apply(1'b1, 8'd0, "R8 late step");
        chk(z_out == 1'b1, "R8 late error", z_out, 1);

        // R6: activity rate at threshold 64 and at threshold 0
        cnt = 0;
        for (int k = 0; k < 2000; k++) begin
            apply(k[0], 8'd64, "R6 rate run");
            cnt += int'(fault_active);
        end
        chk(cnt > 350 && cnt < 650, "R6 rate 64/256", cnt, 500);
        cnt = 0;
        for (int k = 0; k < 200; k++) begin
            apply(k[1], 8'd0, "R6 zero run");
            cnt += int'(fault_active);
        end
        chk(cnt == 0, "R6 rate 0", cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule